// File: doc/BRIEF.md
# Packed BCD Adder-Subtractor

This block adds or subtracts two unsigned decimal numbers held as packed BCD, four bits per digit. A single mode input picks the operation. In add mode the two operands go straight into a chain of decimal digit stages. In subtract mode each digit of the second operand first passes through a nines'-complement network. The lowest stage then receives a carry-in of one, so the chain adds the tens' complement of the subtrahend.

Each digit stage works in two steps. It first forms a plain binary sum of its two digits and its incoming carry. A carry-detect equation then decides whether that sum must be pulled back into decimal range by adding six. The stages ripple their carries from the least significant digit upward. The final carry reports decimal overflow for an addition. For a subtraction it reports whether the difference is non-negative.

A parameter selects either a purely combinational path or a registered output with one cycle of latency. The registered output clears under an active-low asynchronous reset. The digit count is also a parameter.

Top module: `bcd_addsub`

## Requirements
- R1: Field layout. Digit i of each operand and of the result occupies bits [4i+3:4i]. Digit 0 is the least significant digit.
- R2: Add mode (sub_mode = 0). The result is (A + B) mod 10^N in packed BCD, and carry_out is 1 exactly when A + B >= 10^N.
- R3: Subtract mode (sub_mode = 1). The result is (A - B) mod 10^N in packed BCD, where a negative difference appears as its tens' complement. carry_out is 1 exactly when A >= B.
- R4: Digit stage. It forms the binary sum a + b + cin in the range 0 to 19. A correction is applied when that sum carries out of bit 3, or when bit 3 is set together with bit 2 or bit 1. The correction adds 0110 to the low four bits, drops any carry from that second add, and drives the stage carry-out to 1. With no correction the carry-out is 0 and the sum passes unchanged. The result is a sum digit of (a + b + cin) mod 10 and a carry-out of 1 exactly when a + b + cin >= 10.
- R5: Complementer. With mode 0 a digit passes unchanged. With mode 1 the output bits are built as follows, for an output of 9 - d:
  - bit 0 is d0 XOR 1;
  - bit 1 is d1;
  - bit 2 is d2 XOR d1;
  - bit 3 is 1 only when d3, d2 and d1 are all 0.
- R6: The carry-in of digit 0 equals sub_mode. Each stage's carry-out drives the carry-in of the next higher digit. The carry-out of the top digit is carry_out.
- R7: When both operands hold only digits 0 to 9, every result digit is in 0 to 9.
- R8: With REG_OUT = 1, result and carry_out appear one clock after the operands are presented, and both read zero while rst_n is low. With REG_OUT = 0 they follow the inputs combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset of the output register |
| sub_mode | input | 1 | 0 = add, 1 = subtract |
| opa | input | 4*NUM_DIGITS | Packed BCD operand A (minuend) |
| opb | input | 4*NUM_DIGITS | Packed BCD operand B (subtrahend) |
| result | output | 4*NUM_DIGITS | Packed BCD result |
| carry_out | output | 1 | Decimal carry (add) or non-negative flag (subtract) |

## Verification
The bench builds the top with NUM_DIGITS = 4 and REG_OUT = 1. Four digits are enough to exercise carries that ripple across several stages, such as 9999 + 1 and 0000 - 0001. The registered option also brings the reset value and the one-cycle latency within reach. Beside the top, the bench places one digit stage and one complementer on their own. This lets every digit pair with both carry-in values, and every digit in both modes, be driven exhaustively.

// File: rtl/bcd_addsub_pkg.sv
package bcd_addsub_pkg;

  typedef logic [3:0] digit_t;
  typedef logic [4:0] raw_t;

  // Mode-controlled nines' complement built from per-bit equations
  function automatic digit_t nines_comp(input digit_t d, input logic m);
    digit_t r;
    r[0] = d[0] ^ m;
    r[1] = d[1];
    r[2] = m ? (d[2] ^ d[1]) : d[2];
    r[3] = m ? ~(d[3] | d[2] | d[1]) : d[3];
    return r;
  endfunction

  // Plain binary sum of two digits and a carry, range 0..19 for valid input
  function automatic raw_t raw_add(input digit_t a, input digit_t b, input logic c);
    return {1'b0, a} + {1'b0, b} + {4'd0, c};
  endfunction

  // Carry-detect equation: binary carry, or bit 3 with bit 2 or bit 1
  function automatic logic needs_fix(input raw_t r);
    return r[4] | (r[3] & (r[2] | r[1]));
  endfunction

  // Add 0110 when correcting; the carry of this add is dropped
  function automatic digit_t fix_digit(input raw_t r, input logic f);
    digit_t low;
    low = r[3:0];
    return f ? (low + 4'b0110) : low;
  endfunction

endpackage

// File: rtl/bcd_nines_comp.sv
module bcd_nines_comp
  import bcd_addsub_pkg::*;
(
  input  logic [3:0] din,
  input  logic       inv,
  output logic [3:0] dout
);
  always_comb dout = nines_comp(din, inv);
endmodule

// File: rtl/bcd_digit_stage.sv
module bcd_digit_stage
  import bcd_addsub_pkg::*;
(
  input  logic [3:0] a,
  input  logic [3:0] b,
  input  logic       cin,
  output logic [3:0] sum,
  output logic       cout,
  output logic [4:0] raw
);
  logic fix;

  always_comb begin
    raw  = raw_add(a, b, cin);
    fix  = needs_fix(raw);
    sum  = fix_digit(raw, fix);
    cout = fix;
  end
endmodule

// File: rtl/bcd_addsub.sv
module bcd_addsub
  import bcd_addsub_pkg::*;
#(
  parameter int unsigned NUM_DIGITS = 4,
  parameter bit          REG_OUT    = 1'b1
)(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sub_mode,
  input  logic [4*NUM_DIGITS-1:0] opa,
  input  logic [4*NUM_DIGITS-1:0] opb,
  output logic [4*NUM_DIGITS-1:0] result,
  output logic                    carry_out
);
  localparam int unsigned W = 4 * NUM_DIGITS;

  // Named internal events, visible to the bound checker
  logic [NUM_DIGITS:0]     carry_chain;
  logic [W-1:0]            opb_eff;
  logic [W-1:0]            comb_result;
  logic                    comb_cout;
  logic [5*NUM_DIGITS-1:0] stage_raw;

  assign carry_chain[0] = sub_mode;

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_digit
    bcd_nines_comp u_cmp (
      .din  (opb[4*i +: 4]),
      .inv  (sub_mode),
      .dout (opb_eff[4*i +: 4])
    );

    bcd_digit_stage u_stage (
      .a    (opa[4*i +: 4]),
      .b    (opb_eff[4*i +: 4]),
      .cin  (carry_chain[i]),
      .sum  (comb_result[4*i +: 4]),
      .cout (carry_chain[i+1]),
      .raw  (stage_raw[5*i +: 5])
    );
  end

  assign comb_cout = carry_chain[NUM_DIGITS];

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        result    <= '0;
        carry_out <= 1'b0;
      end else begin
        result    <= comb_result;
        carry_out <= comb_cout;
      end
    end
  end else begin : g_comb
    assign result    = comb_result;
    assign carry_out = comb_cout;
  end

endmodule

// File: rtl/bcd_addsub_chk.sv
module bcd_addsub_chk #(
  parameter int unsigned NUM_DIGITS = 4,
  parameter bit          REG_OUT    = 1'b1
)(
  input logic                    clk,
  input logic                    rst_n,
  input logic                    sub_mode,
  input logic [4*NUM_DIGITS-1:0] opa,
  input logic [4*NUM_DIGITS-1:0] opb,
  input logic [4*NUM_DIGITS-1:0] comb_result,
  input logic                    comb_cout,
  input logic [4*NUM_DIGITS-1:0] result,
  input logic                    carry_out,
  input logic [NUM_DIGITS:0]     carry_chain,
  input logic [5*NUM_DIGITS-1:0] stage_raw
);
  function automatic logic all_valid(input logic [4*NUM_DIGITS-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int k = 0; k < NUM_DIGITS; k++) if (v[4*k +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  logic in_ok;
  assign in_ok = all_valid(opa) && all_valid(opb);

  AST_DIGITS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    in_ok |-> all_valid(comb_result)); // R7

  AST_LSD_CARRY_IN: assert property (@(posedge clk) disable iff (!rst_n)
    carry_chain[0] == sub_mode); // R6

  AST_ADD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ok && !sub_mode && opb == '0) |-> (comb_result == opa && !comb_cout)); // R2

  AST_SUB_SELF: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ok && sub_mode && opa == opb) |-> (comb_result == '0 && comb_cout)); // R3

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_stage_chk
    AST_STAGE_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      in_ok |-> (carry_chain[i+1] == (stage_raw[5*i +: 5] >= 5'd10))); // R4
  end

  if (REG_OUT) begin : g_reg_chk
    AST_REG_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (result == $past(comb_result) && carry_out == $past(comb_cout))); // R8
  end else begin : g_comb_chk
    AST_COMB_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      result == comb_result && carry_out == comb_cout); // R8
  end
endmodule

bind bcd_addsub bcd_addsub_chk #(
  .NUM_DIGITS (NUM_DIGITS),
  .REG_OUT    (REG_OUT)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sub_mode    (sub_mode),
  .opa         (opa),
  .opb         (opb),
  .comb_result (comb_result),
  .comb_cout   (comb_cout),
  .result      (result),
  .carry_out   (carry_out),
  .carry_chain (carry_chain),
  .stage_raw   (stage_raw)
);

// File: tb/bcd_addsub_bench.sv
module bcd_addsub_bench;
  localparam int ND  = 4;
  localparam int W   = 4 * ND;
  localparam int MOD = 10000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sub_mode = 1'b0;
  logic [W-1:0] opa = '0, opb = '0;
  logic [W-1:0] result;
  logic         carry_out;

  logic [3:0] sa = '0, sb = '0, ssum;
  logic       scin = 1'b0, scout;
  logic [4:0] sraw;
  logic [3:0] cin_d = '0, cout_d;
  logic       cm = 1'b0;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  bcd_addsub #(.NUM_DIGITS(ND), .REG_OUT(1'b1)) u_bcd_addsub (
    .clk(clk), .rst_n(rst_n), .sub_mode(sub_mode), .opa(opa), .opb(opb),
    .result(result), .carry_out(carry_out));

  bcd_digit_stage u_stage (.a(sa), .b(sb), .cin(scin), .sum(ssum), .cout(scout), .raw(sraw));
  bcd_nines_comp  u_cmp   (.din(cin_d), .inv(cm), .dout(cout_d));

  function automatic logic [W-1:0] to_bcd(input int v);
    logic [W-1:0] r;
    int t;
    t = v;
    for (int k = 0; k < ND; k++) begin
      r[4*k +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_op(input string req, input logic m, input int a, input int b);
    int expv;
    logic expc;
    @(negedge clk);
    sub_mode = m;
    opa = to_bcd(a);
    opb = to_bcd(b);
    if (!m) begin
      expv = (a + b) % MOD;
      expc = (a + b) >= MOD;
    end else begin
      expv = (a >= b) ? (a - b) : (MOD - (b - a));
      expc = (a >= b);
    end
    @(posedge clk);
    @(negedge clk);
    check(req, {carry_out, result}, {expc, to_bcd(expv)});
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    // R8: reset state of the registered output
    opa = to_bcd(1234); opb = to_bcd(5678);
    repeat (3) @(negedge clk);
    check("R8 reset", {carry_out, result}, '0);
    rst_n = 1'b1;

    // R4: exhaustive digit stage, every pair and carry-in
    for (int a = 0; a < 10; a++)
      for (int b = 0; b < 10; b++)
        for (int c = 0; c < 2; c++) begin
          sa = 4'(a); sb = 4'(b); scin = 1'(c);
          #1;
          check("R4 stage", {12'd0, scout, ssum}, {12'd0, 1'((a+b+c) >= 10), 4'((a+b+c) % 10)});
        end

    // R5: complementer, every digit in both modes
    for (int d = 0; d < 10; d++)
      for (int m = 0; m < 2; m++) begin
        cin_d = 4'(d); cm = 1'(m);
        #1;
        check("R5 comp", {13'd0, cout_d}, {13'd0, (m != 0) ? 4'(9 - d) : 4'(d)});
      end

    // Directed corners
    run_op("R2 add ripple 9999+1", 1'b0, 9999, 1);
    run_op("R2 add max", 1'b0, 9999, 9999);
    run_op("R2 add zero", 1'b0, 0, 0);
    run_op("R1 digit order", 1'b0, 1000, 20);
    run_op("R3 sub borrow 0-1", 1'b1, 0, 1);
    run_op("R3 sub equal", 1'b1, 4567, 4567);
    run_op("R3 sub 5000-4999", 1'b1, 5000, 4999);
    run_op("R6 sub 0-0 lsd carry", 1'b1, 0, 0);
    run_op("R3 sub 0-9999", 1'b1, 0, 9999);

    // Random mix, both modes; R7 digit range checked through exact match
    for (int n = 0; n < 400; n++) begin
      int ra, rb;
      logic rm;
      ra = int'($urandom % MOD);
      rb = int'($urandom % MOD);
      rm = 1'($urandom % 2);
      run_op(rm ? "R3 sub random R7" : "R2 add random R7", rm, ra, rb);
    end

    // R8: result holds one cycle behind the operands
    @(negedge clk);
    sub_mode = 1'b0; opa = to_bcd(11); opb = to_bcd(22);
    @(posedge clk); @(negedge clk);
    opa = to_bcd(3); opb = to_bcd(4);
    #1;
    check("R8 latency hold", {carry_out, result}, {1'b0, to_bcd(33)});
    @(posedge clk); @(negedge clk);
    check("R8 latency update", {carry_out, result}, {1'b0, to_bcd(7)});

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule